// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a real-time clock that counts time of day and date in packed BCD. A one-second tick input advances the counters. The counters are seconds, minutes, hours, day of month, month, two-digit year and a weekday. Software reaches the block through a byte-wide register port. It can load the time, arm a six-field alarm, choose a periodic event and enable either interrupt source. The block drives a single level interrupt line.

Time reads are coherent across bytes. A command bit in the control register copies the live counters into a static shadow bank, and the time addresses read from that bank. A run bit gates counting so that software can load a new time while the counters are frozen. The event and alarm flags stay set until software writes a one to clear them.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time is 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0. Control reads 0x00, status reads 0x80 (power-up flag only), interrupt enable reads 0x00 and `irq` is low.
- R2: Register offsets:
  - time fields: seconds 0x00, minutes 0x01, hours 0x02, day 0x03, month 0x04, year 0x05, weekday 0x06;
  - alarm fields: alarm seconds through alarm year at 0x07 to 0x0C, in the same field order as the time fields;
  - control 0x0D, status 0x0E, interrupt enable 0x0F.
  - A write to 0x00 to 0x06 loads the live counter directly.
- R3: Each counted tick advances seconds. Seconds and minutes wrap from 0x59 to 0x00 and hours wrap from 0x23 to 0x00, each wrap carrying into the next field. A BCD digit of 9 carries into the tens digit.
- R4: When hours wrap, these fields advance:
  - Day returns to 0x01 after the month's last day. Months 04, 06, 09 and 11 have 30 days. February has 29 days when the binary value of the BCD year is divisible by 4, and 28 days otherwise. All other months have 31 days.
  - Month wraps from 0x12 to 0x01, and year wraps from 0x99 to 0x00.
  - Weekday counts 0 to 6 and then returns to 0.
- R5: Counting happens only while control bit 0 (run) is 1. With run at 0, ticks leave every counter unchanged.
- R6: Writing control with bit 6 set copies the live seconds to year into the shadow bank. Reads of 0x00 to 0x05 always return the shadow bank, so later ticks do not change them until the next copy. Control bit 6 reads back as 0 and every other control bit reads back as written.
- R7: Status bit 1 mirrors the run bit. A counted tick sets status bit 2. A seconds wrap sets bit 3, a minutes wrap sets bit 4 and an hours wrap sets bit 5.
- R8: Writing a 1 to status bits 2 to 7 clears those flags. Bits written as 0 keep their value. The power-up flag (bit 7) is set only by reset.
- R9: Status bit 6 is set by a counted tick whose new seconds-to-year values all equal the alarm registers.
- R10: `irq` = (status[6] AND enable[3]) OR (selected periodic flag AND enable[2]). Enable bits 1:0 select the periodic flag: 0 selects status bit 2, 1 selects bit 3, 2 selects bit 4 and 3 selects bit 5. Interrupt-enable bits 7:4 read as 0.
- R11: `rdata` loads the addressed register on a clock edge where `rd_en` is 1 and holds its value otherwise. Unmapped addresses read 0x00, and the weekday register reads as {5'b0, weekday}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1s | input | 1 | One-cycle pulse per second |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest condition to reach is the cascade in which every field wraps on one tick. This includes the day rollover at the end of February in leap and non-leap years and the wrap from year 99 to year 00. Reaching these by counting ticks would take years of simulated time.

The stimulus instead stops the clock, loads a time one second before each boundary through the live-counter addresses, and then runs for exactly one tick. A snapshot with run cleared freezes the result for reading. The flags are cleared before each tick, so the event bits read back belong to that tick alone.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int N_FLD   = 6;   // sec, min, hr, day, mon, yr
    localparam int OFF_WDAY = 6;
    localparam int OFF_ALM  = 7;
    localparam int OFF_CTRL = 13;
    localparam int OFF_STAT = 14;
    localparam int OFF_IEN  = 15;

    typedef logic [7:0] bcd_t;

    typedef struct packed {
        bcd_t       sec;
        bcd_t       min;
        bcd_t       hr;
        bcd_t       day;
        bcd_t       mon;
        bcd_t       yr;
        logic [2:0] wday;
    } tod_t;

    typedef struct packed {
        logic [7:0]             ctrl;
        logic [3:0]             ien;
        logic [7:0]             stat;
        logic [N_FLD-1:0][7:0]  alm;
        logic [N_FLD-1:0][7:0]  shad;
        logic [7:0]             rdata;
    } regs_t;

    function automatic bcd_t bcd_inc(bcd_t v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    function automatic bcd_t month_last(bcd_t mon, bcd_t yr);
        logic [6:0] yb;
        yb = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
        case (mon)
            8'h02:                      return (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       ld_en,
    input  logic [2:0] ld_sel,
    input  logic [7:0] ld_val,
    output tod_t       now_q,
    output tod_t       nxt_d,
    output logic       ev_sec,
    output logic       ev_min,
    output logic       ev_hr,
    output logic       ev_day
);
    localparam tod_t TOD_RST = '{sec: 8'h00, min: 8'h00, hr: 8'h00, day: 8'h01,
                                 mon: 8'h01, yr: 8'h00, wday: 3'd0};

    always_comb begin
        nxt_d  = now_q;
        ev_sec = 1'b0;
        ev_min = 1'b0;
        ev_hr  = 1'b0;
        ev_day = 1'b0;
        if (ld_en) begin
            case (ld_sel)
                3'd0:    nxt_d.sec  = ld_val;
                3'd1:    nxt_d.min  = ld_val;
                3'd2:    nxt_d.hr   = ld_val;
                3'd3:    nxt_d.day  = ld_val;
                3'd4:    nxt_d.mon  = ld_val;
                3'd5:    nxt_d.yr   = ld_val;
                default: nxt_d.wday = ld_val[2:0];
            endcase
        end else if (adv) begin
            ev_sec = 1'b1;
            if (now_q.sec != 8'h59) begin
                nxt_d.sec = bcd_inc(now_q.sec);
            end else begin
                nxt_d.sec = 8'h00;
                ev_min    = 1'b1;
                if (now_q.min != 8'h59) begin
                    nxt_d.min = bcd_inc(now_q.min);
                end else begin
                    nxt_d.min = 8'h00;
                    ev_hr     = 1'b1;
                    if (now_q.hr != 8'h23) begin
                        nxt_d.hr = bcd_inc(now_q.hr);
                    end else begin
                        nxt_d.hr   = 8'h00;
                        ev_day     = 1'b1;
                        nxt_d.wday = (now_q.wday >= 3'd6) ? 3'd0 : now_q.wday + 3'd1;
                        if (now_q.day != month_last(now_q.mon, now_q.yr)) begin
                            nxt_d.day = bcd_inc(now_q.day);
                        end else begin
                            nxt_d.day = 8'h01;
                            if (now_q.mon != 8'h12) begin
                                nxt_d.mon = bcd_inc(now_q.mon);
                            end else begin
                                nxt_d.mon = 8'h01;
                                nxt_d.yr  = (now_q.yr == 8'h99) ? 8'h00 : bcd_inc(now_q.yr);
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) now_q <= TOD_RST;
        else        now_q <= nxt_d;
    end

    // R5: with no count and no load the counters hold
    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !ld_en) |=> $stable(now_q));

    // R4: a full-day wrap always moves the weekday
    assert_wday_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld_en && now_q.sec == 8'h59 && now_q.min == 8'h59 && now_q.hr == 8'h23)
        |=> (now_q.wday != $past(now_q.wday)));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_pkg::*;
#(
    parameter int NF = N_FLD
) (
    input  logic [NF-1:0][7:0] tv,
    input  logic [NF-1:0][7:0] alm,
    output logic               hit
);
    logic [NF-1:0] eq;
    for (genvar i = 0; i < NF; i++) begin : g_cmp
        assign eq[i] = (tv[i] == alm[i]);
    end
    assign hit = &eq;
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] AD_WDAY = ADDR_W'(OFF_WDAY);
    localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(OFF_IEN);
    localparam logic [N_FLD-1:0][7:0] SHAD_RST = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    regs_t q, d;
    tod_t  now, nxt;
    logic  ev_sec, ev_min, ev_hr, ev_day, alm_hit;
    logic  wr_time, adv, per_flag;
    logic [N_FLD-1:0][7:0] live_v, nxt_v;

    assign wr_time = wr_en && (addr <= AD_WDAY);
    assign adv     = tick_1s && q.ctrl[0] && !wr_time;
    assign live_v  = {now.yr, now.mon, now.day, now.hr, now.min, now.sec};
    assign nxt_v   = {nxt.yr, nxt.mon, nxt.day, nxt.hr, nxt.min, nxt.sec};

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .adv(adv), .ld_en(wr_time),
        .ld_sel(addr[2:0]), .ld_val(wdata), .now_q(now), .nxt_d(nxt),
        .ev_sec(ev_sec), .ev_min(ev_min), .ev_hr(ev_hr), .ev_day(ev_day)
    );

    rtc_alarm_match #(.NF(N_FLD)) u_alm (.tv(nxt_v), .alm(q.alm), .hit(alm_hit));

    always_comb begin
        d = q;
        if (wr_en) begin
            if (addr == AD_CTRL) begin
                d.ctrl = wdata & 8'hBF;
                if (wdata[6]) d.shad = live_v;
            end else if (addr == AD_IEN) begin
                d.ien = wdata[3:0];
            end else if (addr == AD_STAT) begin
                d.stat[7:2] = q.stat[7:2] & ~wdata[7:2];
            end
            for (int i = 0; i < N_FLD; i++)
                if (int'(addr) == OFF_ALM + i) d.alm[i] = wdata;
        end
        d.stat[2] = d.stat[2] | ev_sec;
        d.stat[3] = d.stat[3] | ev_min;
        d.stat[4] = d.stat[4] | ev_hr;
        d.stat[5] = d.stat[5] | ev_day;
        d.stat[6] = d.stat[6] | (adv & alm_hit);
        if (rd_en) begin
            d.rdata = 8'h00;
            for (int i = 0; i < N_FLD; i++) begin
                if (int'(addr) == i)           d.rdata = q.shad[i];
                if (int'(addr) == OFF_ALM + i) d.rdata = q.alm[i];
            end
            if (addr == AD_WDAY) d.rdata = {5'd0, now.wday};
            if (addr == AD_CTRL) d.rdata = q.ctrl;
            if (addr == AD_STAT) d.rdata = {q.stat[7:2], q.ctrl[0], 1'b0};
            if (addr == AD_IEN)  d.rdata = {4'd0, q.ien};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctrl  <= 8'h00;
            q.ien   <= 4'h0;
            q.stat  <= 8'h80;
            q.alm   <= '0;
            q.shad  <= SHAD_RST;
            q.rdata <= 8'h00;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.ien[1:0])
            2'd0:    per_flag = q.stat[2];
            2'd1:    per_flag = q.stat[3];
            2'd2:    per_flag = q.stat[4];
            default: per_flag = q.stat[5];
        endcase
    end

    assign irq   = (q.stat[6] & q.ien[3]) | (per_flag & q.ien[2]);
    assign rdata = q.rdata;

    // R10: the line needs a pending flag behind it
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (q.stat[6] || (q.stat[5:2] != 4'd0)));

    // R8: one written to the power-up flag removes it for good
    assert_w1c_pwrup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AD_STAT && wdata[7]) |=> !q.stat[7]);

    // R6: the copy holds the counter value of the write cycle
    assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AD_CTRL && wdata[6]) |=> (q.shad[0] == $past(now.sec)));

    // R11: rdata moves only on a read
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_bcd_rtc.sv
module sim_bcd_rtc;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;
    // {start sec,min,hr,day,mon,yr,wday ; expected after one tick}
    localparam logic [111:0] VEC [NV] = '{
        {56'h00_00_00_01_01_00_00, 56'h01_00_00_01_01_00_00},
        {56'h09_09_00_01_01_00_00, 56'h10_09_00_01_01_00_00},
        {56'h59_34_12_15_06_23_03, 56'h00_35_12_15_06_23_03},
        {56'h59_59_12_15_06_23_03, 56'h00_00_13_15_06_23_03},
        {56'h59_59_23_28_02_24_01, 56'h00_00_00_29_02_24_02},
        {56'h59_59_23_29_02_24_02, 56'h00_00_00_01_03_24_03},
        {56'h59_59_23_28_02_23_04, 56'h00_00_00_01_03_23_05},
        {56'h59_59_23_28_02_00_05, 56'h00_00_00_29_02_00_06},
        {56'h59_59_23_31_12_99_06, 56'h00_00_00_01_01_00_00},
        {56'h59_59_23_30_04_21_00, 56'h00_00_00_01_05_21_01},
        {56'h59_59_23_30_01_21_01, 56'h00_00_00_31_01_21_02},
        {56'h59_59_23_31_07_05_02, 56'h00_00_00_01_08_05_03},
        {56'h59_59_23_30_11_16_03, 56'h00_00_00_01_12_16_04}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1s = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       irq;
    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] v;
    logic [55:0] got;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bcd_rtc u0 (.clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .addr(addr), .wdata(wdata),
                .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] dat);
        @(negedge clk); addr = a; wdata = dat; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] dat);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; dat = rdata;
    endtask

    task automatic tick();
        @(negedge clk); tick_1s = 1'b1;
        @(negedge clk); tick_1s = 1'b0;
    endtask

    task automatic load(input logic [55:0] t);
        for (int a = 0; a < 7; a++) wr(5'(a), t[55-8*a -: 8]);
    endtask

    task automatic read_time(output logic [55:0] t);
        logic [7:0] b;
        for (int a = 0; a < 7; a++) begin
            rd(5'(a), b);
            t[55-8*a -: 8] = b;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", 64'(irq), 64'h0);
        rd(5'h0E, v); chk("R1 status", 64'(v), 64'h80);
        rd(5'h0D, v); chk("R1 control", 64'(v), 64'h00);
        rd(5'h0F, v); chk("R1 ienable", 64'(v), 64'h00);
        read_time(got); chk("R1 time", 64'(got), 64'h00_00_00_01_01_00_00);
        // R11 hold without read strobe
        rd(5'h0E, v);
        @(negedge clk); addr = 5'h0D;
        @(negedge clk); chk("R11 rdata holds", 64'(rdata), 64'h80);
        rd(5'h13, v); chk("R11 unmapped", 64'(v), 64'h00);
        // R8 write-one-to-clear
        wr(5'h0E, 8'h00); rd(5'h0E, v); chk("R8 zero write keeps", 64'(v), 64'h80);
        wr(5'h0E, 8'h7F); rd(5'h0E, v); chk("R8 other bits keep", 64'(v), 64'h80);
        wr(5'h0E, 8'h80); rd(5'h0E, v); chk("R8 power-up cleared", 64'(v), 64'h00);
        // R2 alarm bank, unreachable in the table
        for (int a = 0; a < 6; a++) wr(5'(7 + a), (a == 5) ? 8'h77 : ((a >= 3) ? 8'h01 : 8'h00));
        rd(5'h0C, v); chk("R2 alarm year readback", 64'(v), 64'h77);
        rd(5'h0A, v); chk("R2 alarm day readback", 64'(v), 64'h01);

        // table walk: R3 R4 R7
        for (int i = 0; i < NV; i++) begin
            logic [55:0] st, ex;
            logic [7:0]  fl;
            st = VEC[i][111:56];
            ex = VEC[i][55:0];
            wr(5'h0D, 8'h00);
            load(st);
            wr(5'h0E, 8'hFC);
            wr(5'h0D, 8'h01);
            tick();
            wr(5'h0D, 8'h40);
            read_time(got);
            chk($sformatf("R3/R4 vector %0d", i), 64'(got), 64'(ex));
            fl = 8'h04;
            if (ex[55:48] == 8'h00) fl |= 8'h08;
            if (ex[55:40] == 16'h0) fl |= 8'h10;
            if (ex[55:32] == 24'h0) fl |= 8'h20;
            rd(5'h0E, v);
            chk($sformatf("R7 flags vector %0d", i), 64'(v), 64'(fl));
        end

        // R5 run gate
        wr(5'h0D, 8'h00);
        load(56'h20_00_00_01_01_00_00);
        tick(); tick(); tick();
        wr(5'h0D, 8'h40);
        rd(5'h00, v); chk("R5 stopped", 64'(v), 64'h20);
        // R6 snapshot, control readback, R7 run mirror
        wr(5'h0D, 8'h01);
        tick(); tick();
        wr(5'h0D, 8'h41);
        rd(5'h00, v); chk("R6 snapshot", 64'(v), 64'h22);
        tick();
        rd(5'h00, v); chk("R6 shadow static", 64'(v), 64'h22);
        rd(5'h0D, v); chk("R6 control readback", 64'(v), 64'h01);
        rd(5'h0E, v); chk("R7 run mirror", 64'(v & 8'h02), 64'h02);

        // R9 alarm and R10 irq
        wr(5'h0D, 8'h00);
        load(56'h09_00_00_01_01_00_00);
        wr(5'h07, 8'h10); wr(5'h08, 8'h00); wr(5'h09, 8'h00);
        wr(5'h0A, 8'h01); wr(5'h0B, 8'h01); wr(5'h0C, 8'h00);
        wr(5'h0E, 8'hFC);
        wr(5'h0F, 8'h08);
        wr(5'h0D, 8'h01);
        chk("R10 no alarm yet", 64'(irq), 64'h0);
        tick();
        chk("R10 alarm irq", 64'(irq), 64'h1);
        rd(5'h0E, v); chk("R9 alarm flag", 64'(v & 8'h40), 64'h40);
        wr(5'h0E, 8'h40);
        chk("R10 alarm cleared", 64'(irq), 64'h0);
        // periodic select: minute
        wr(5'h0F, 8'h05);
        wr(5'h0E, 8'hFC);
        tick();
        chk("R10 minute not yet", 64'(irq), 64'h0);
        rd(5'h0E, v); chk("R7 second flag", 64'(v & 8'h3C), 64'h04);
        wr(5'h00, 8'h59);
        tick();
        chk("R10 minute irq", 64'(irq), 64'h1);
        wr(5'h0F, 8'h06);
        chk("R10 hour not set", 64'(irq), 64'h0);
        wr(5'h0F, 8'h04);
        chk("R10 second select", 64'(irq), 64'h1);
        wr(5'h0F, 8'h00);
        chk("R10 disabled", 64'(irq), 64'h0);
        rd(5'h0F, v); chk("R10 ienable readback", 64'(v), 64'h00);
        summary();
    end
endmodule